// File: doc/BRIEF.md
# ADC Power-Up Sequencer

This block runs on the host side of an isolated delta-sigma ADC. It takes the converter from power-on to a state where its conversion results can be used. It watches the ADC's data-ready line and sends register writes and status reads through a one-at-a-time command/response handshake to an external SPI master. It controls the gate on the ADC's main clock and drives the active-low sync/reset line. Once the output is valid, it drops the unsettled conversion results and then raises a ready flag.

The startup runs in a fixed order:

1. Wait for data-ready to rise.
2. Write the clock divider.
3. Write the DC-DC frequency with the converter still disabled.
4. Write the same frequency again with the enable bit set.
5. Write the remaining registers.
6. Open the ADC clock.
7. Clear the latched secondary-fail flag with one status read whose result is thrown away.
8. Poll the flag, with a programmable gap between reads, until it reads zero.
9. Pulse sync.
10. Count off the unsettled results and assert ready.

Two waits are guarded by cycle-count timeouts: the data-ready rise and the status poll. If either expires, the block sets a sticky error flag and stops until reset.

Top module: `adc_pwrup_seq`

## Requirements
- R1: After reset no request is issued until a low-to-high transition is seen on `drdy` (the synchronised line resets to low).
- R2: The first request writes `cfg_clk_div << CLKDIV_LSB` (bit 8) to address `CLK_ADDR` (3). The second writes `cfg_dcdc_freq << FREQ_LSB` (bit 4) to `DCDC_ADDR` (7) with enable bit `EN_BIT` (0) clear.
- R3: The third request writes the same frequency word to `DCDC_ADDR` with bit `EN_BIT` set. Then, for each i, it writes slice i of `cfg_extra` (bits i*16 upward) to address `EXTRA_BASE+i` (16+i). A request holds its fields while `cmd_ready` is low.
- R4: `adc_clk_en` is 0 from reset through every configuration write. It is 1 before the first status request is issued.
- R5: The response to the first status request is ignored, even when it reads clear, and a second status request always follows.
- R6: Status polling continues while bit `SECFAIL_BIT` (12) of the response is 1. It stops at the first response with that bit 0.
- R7: With `status_via_null`=1, a status request is a NULL command (`cmd_null`=1, `cmd_write`=0). With it 0, the request is a register read (`cmd_null`=0, `cmd_write`=0) of `STATUS_ADDR` (1).
- R8: Between a status response and the next status request there are at least `POLL_GAP` cycles.
- R9: After the clear status read, `adc_sync_n` goes low for exactly `SYNC_LEN` cycles. `samples_ready` stays 0 until the pulse is over.
- R10: After the sync pulse, `samples_ready` rises only once `DISCARD` falling edges of `drdy` have been counted. It then stays high.
- R11: If `drdy` does not rise within `RISE_TMO` cycles of reset, `seq_error` is set. It then stays set, no request is issued and the clock stays gated, even if `drdy` rises later.
- R12: If the poll does not read clear within `POLL_TMO` cycles, `seq_error` is set and stays set. No further request, no sync pulse and no ready follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drdy | input | 1 | ADC data-ready line (asynchronous) |
| status_via_null | input | 1 | 1: status via NULL command, 0: via register read |
| cfg_clk_div | input | 2 | Clock divider field value |
| cfg_dcdc_freq | input | 4 | DC-DC / modulator frequency field value |
| cfg_extra | input | N_EXTRA*DATA_W | Words for the remaining configuration registers |
| cmd_valid | output | 1 | Request valid |
| cmd_ready | input | 1 | Request accepted by SPI master |
| cmd_write | output | 1 | 1 = register write, 0 = read |
| cmd_null | output | 1 | Request is a NULL command |
| cmd_addr | output | ADDR_W | Register address |
| cmd_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Response strobe, one per accepted request |
| rsp_rdata | input | DATA_W | Response data (status word for reads) |
| adc_clk_en | output | 1 | Gate enable for the ADC main clock |
| adc_sync_n | output | 1 | Active-low sync/reset pulse |
| samples_ready | output | 1 | Conversion results are valid and settled |
| seq_error | output | 1 | Sticky timeout error |

## Verification
The bench builds the block with small timing parameters:

| Parameter | Value |
|---|---|
| `RISE_TMO` | 200 |
| `POLL_TMO` | 300 |
| `POLL_GAP` | 8 |
| `SYNC_LEN` | 4 |
| `DISCARD` | 2 |
| `N_EXTRA` | 2 |

With these values both timeout paths can be reached in a few hundred cycles. The status poll runs several rounds, including a first response that already reads clear but must still be discarded. The exact sync pulse width and the discard count are measured edge by edge, and both status access modes are driven through the full bring-up.

// File: rtl/apu_pkg.sv
package apu_pkg;
  typedef enum logic [3:0] {
    S_WAIT_RISE,
    S_CFG_REQ,
    S_CFG_RSP,
    S_CLK_ON,
    S_STAT_REQ,
    S_STAT_RSP,
    S_GAP,
    S_SYNC,
    S_DISCARD,
    S_READY,
    S_ERR
  } apu_state_e;
endpackage

// File: rtl/apu_edge_sync.sv
module apu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      last <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      last <= sh[STAGES-1];
      rise <= sh[STAGES-1] & ~last;
      fall <= ~sh[STAGES-1] & last;
    end
  end
endmodule

// File: rtl/apu_timer.sv
module apu_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] span,
  output logic         done
);
  logic [W-1:0] cnt;

  // Reloads while idle, counts down while running, done once it hits zero.
  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= span;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/apu_cfg_table.sv
module apu_cfg_table #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int N_EXTRA    = 2,
  parameter int IDX_W      = 3,
  parameter int CLK_ADDR   = 3,
  parameter int DCDC_ADDR  = 7,
  parameter int EXTRA_BASE = 16,
  parameter int CLKDIV_LSB = 8,
  parameter int FREQ_LSB   = 4,
  parameter int EN_BIT     = 0
) (
  input  logic [IDX_W-1:0]          idx,
  input  logic [1:0]                clk_div,
  input  logic [3:0]                freq,
  input  logic [N_EXTRA*DATA_W-1:0] extra,
  output logic [ADDR_W-1:0]         addr,
  output logic [DATA_W-1:0]         data
);
  localparam int N_WR = 3 + N_EXTRA;

  logic [ADDR_W-1:0] tab_a [N_WR];
  logic [DATA_W-1:0] tab_d [N_WR];
  logic [DATA_W-1:0] freq_word;

  assign freq_word = DATA_W'(freq) << FREQ_LSB;

  for (genvar i = 0; i < N_WR; i++) begin : g_ent
    if (i == 0) begin : g_div
      assign tab_a[i] = ADDR_W'(CLK_ADDR);
      assign tab_d[i] = DATA_W'(clk_div) << CLKDIV_LSB;
    end else if (i == 1) begin : g_freq
      assign tab_a[i] = ADDR_W'(DCDC_ADDR);
      assign tab_d[i] = freq_word;
    end else if (i == 2) begin : g_en
      assign tab_a[i] = ADDR_W'(DCDC_ADDR);
      assign tab_d[i] = freq_word | (DATA_W'(1) << EN_BIT);
    end else begin : g_extra
      assign tab_a[i] = ADDR_W'(EXTRA_BASE + i - 3);
      assign tab_d[i] = extra[(i-3)*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    addr = '0;
    data = '0;
    if (int'(idx) < N_WR) begin
      addr = tab_a[idx];
      data = tab_d[idx];
    end
  end
endmodule

// File: rtl/adc_pwrup_seq.sv
module adc_pwrup_seq
  import apu_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int N_EXTRA     = 2,
  parameter int TMO_W       = 20,
  parameter int RISE_TMO    = 100000,
  parameter int POLL_TMO    = 500000,
  parameter int POLL_GAP    = 64,
  parameter int SYNC_LEN    = 8,
  parameter int DISCARD     = 2,
  parameter int CLK_ADDR    = 3,
  parameter int DCDC_ADDR   = 7,
  parameter int STATUS_ADDR = 1,
  parameter int EXTRA_BASE  = 16,
  parameter int CLKDIV_LSB  = 8,
  parameter int FREQ_LSB    = 4,
  parameter int EN_BIT      = 0,
  parameter int SECFAIL_BIT = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      drdy,
  input  logic                      status_via_null,
  input  logic [1:0]                cfg_clk_div,
  input  logic [3:0]                cfg_dcdc_freq,
  input  logic [N_EXTRA*DATA_W-1:0] cfg_extra,
  output logic                      cmd_valid,
  input  logic                      cmd_ready,
  output logic                      cmd_write,
  output logic                      cmd_null,
  output logic [ADDR_W-1:0]         cmd_addr,
  output logic [DATA_W-1:0]         cmd_wdata,
  input  logic                      rsp_valid,
  input  logic [DATA_W-1:0]         rsp_rdata,
  output logic                      adc_clk_en,
  output logic                      adc_sync_n,
  output logic                      samples_ready,
  output logic                      seq_error
);
  localparam int N_WR   = 3 + N_EXTRA;
  localparam int IDX_W  = (N_WR > 1) ? $clog2(N_WR) : 1;
  localparam int DISC_W = $clog2(DISCARD + 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WR - 1);

  apu_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              first_q, first_d;
  logic [DISC_W-1:0] disc_q, disc_d;

  logic drdy_rise, drdy_fall;
  logic rise_tmo, poll_tmo, gap_done, sync_done;
  logic polling;
  logic [ADDR_W-1:0] tab_addr;
  logic [DATA_W-1:0] tab_data;
  logic handshake, enter_req;

  apu_edge_sync #(.STAGES(2)) u_drdy (
    .clk (clk), .rst (rst), .din (drdy), .rise (drdy_rise), .fall (drdy_fall)
  );

  assign polling = (state_q == S_STAT_REQ) || (state_q == S_STAT_RSP) || (state_q == S_GAP);

  apu_timer #(.W(TMO_W)) u_rise_tmo (
    .clk (clk), .rst (rst), .run (state_q == S_WAIT_RISE),
    .span (TMO_W'(RISE_TMO)), .done (rise_tmo)
  );

  apu_timer #(.W(TMO_W)) u_poll_tmo (
    .clk (clk), .rst (rst), .run (polling),
    .span (TMO_W'(POLL_TMO)), .done (poll_tmo)
  );

  apu_timer #(.W(TMO_W)) u_gap (
    .clk (clk), .rst (rst), .run (state_q == S_GAP),
    .span (TMO_W'(POLL_GAP)), .done (gap_done)
  );

  apu_timer #(.W(TMO_W)) u_sync (
    .clk (clk), .rst (rst), .run (state_q == S_SYNC),
    .span (TMO_W'(SYNC_LEN - 1)), .done (sync_done)
  );

  apu_cfg_table #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .N_EXTRA (N_EXTRA), .IDX_W (IDX_W),
    .CLK_ADDR (CLK_ADDR), .DCDC_ADDR (DCDC_ADDR), .EXTRA_BASE (EXTRA_BASE),
    .CLKDIV_LSB (CLKDIV_LSB), .FREQ_LSB (FREQ_LSB), .EN_BIT (EN_BIT)
  ) u_tab (
    .idx (idx_d), .clk_div (cfg_clk_div), .freq (cfg_dcdc_freq),
    .extra (cfg_extra), .addr (tab_addr), .data (tab_data)
  );

  assign handshake = cmd_valid && cmd_ready;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    first_d = first_q;
    disc_d  = disc_q;
    case (state_q)
      S_WAIT_RISE: begin
        if (rise_tmo) state_d = S_ERR;
        else if (drdy_rise) begin
          state_d = S_CFG_REQ;
          idx_d   = '0;
        end
      end
      S_CFG_REQ: if (handshake) state_d = S_CFG_RSP;
      S_CFG_RSP: begin
        if (rsp_valid) begin
          if (idx_q == LAST_IDX) state_d = S_CLK_ON;
          else begin
            idx_d   = idx_q + 1'b1;
            state_d = S_CFG_REQ;
          end
        end
      end
      S_CLK_ON: begin
        first_d = 1'b1;
        state_d = S_STAT_REQ;
      end
      S_STAT_REQ: begin
        if (poll_tmo) state_d = S_ERR;
        else if (handshake) state_d = S_STAT_RSP;
      end
      S_STAT_RSP: begin
        if (poll_tmo) state_d = S_ERR;
        else if (rsp_valid) begin
          if (first_q) begin
            first_d = 1'b0;
            state_d = S_GAP;
          end else if (!rsp_rdata[SECFAIL_BIT]) state_d = S_SYNC;
          else state_d = S_GAP;
        end
      end
      S_GAP: begin
        if (poll_tmo) state_d = S_ERR;
        else if (gap_done) state_d = S_STAT_REQ;
      end
      S_SYNC: begin
        disc_d = '0;
        if (sync_done) state_d = S_DISCARD;
      end
      S_DISCARD: begin
        if (disc_q == DISC_W'(DISCARD)) state_d = S_READY;
        else if (drdy_fall) disc_d = disc_q + 1'b1;
      end
      S_READY: state_d = S_READY;
      S_ERR:   state_d = S_ERR;
      default: state_d = S_ERR;
    endcase
  end

  assign enter_req = ((state_d == S_CFG_REQ) || (state_d == S_STAT_REQ)) && (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_WAIT_RISE;
      idx_q         <= '0;
      first_q       <= 1'b1;
      disc_q        <= '0;
      cmd_valid     <= 1'b0;
      cmd_write     <= 1'b0;
      cmd_null      <= 1'b0;
      cmd_addr      <= '0;
      cmd_wdata     <= '0;
      adc_clk_en    <= 1'b0;
      adc_sync_n    <= 1'b1;
      samples_ready <= 1'b0;
      seq_error     <= 1'b0;
    end else begin
      state_q       <= state_d;
      idx_q         <= idx_d;
      first_q       <= first_d;
      disc_q        <= disc_d;
      cmd_valid     <= (state_d == S_CFG_REQ) || (state_d == S_STAT_REQ);
      if (enter_req) begin
        if (state_d == S_CFG_REQ) begin
          cmd_write <= 1'b1;
          cmd_null  <= 1'b0;
          cmd_addr  <= tab_addr;
          cmd_wdata <= tab_data;
        end else begin
          cmd_write <= 1'b0;
          cmd_null  <= status_via_null;
          cmd_addr  <= status_via_null ? '0 : ADDR_W'(STATUS_ADDR);
          cmd_wdata <= '0;
        end
      end
      adc_clk_en    <= adc_clk_en | (state_d == S_CLK_ON);
      adc_sync_n    <= (state_d != S_SYNC);
      samples_ready <= (state_d == S_READY);
      seq_error     <= seq_error | (state_d == S_ERR);
    end
  end
endmodule

// File: rtl/apu_checker.sv
module apu_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              drdy,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic              cmd_null,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              adc_clk_en,
  input logic              adc_sync_n,
  input logic              samples_ready,
  input logic              seq_error
);
  logic drdy_seen, sync_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_seen <= 1'b0;
      sync_seen <= 1'b0;
    end else begin
      drdy_seen <= drdy_seen | drdy;
      sync_seen <= sync_seen | ~adc_sync_n;
    end
  end

  assert_no_cmd_before_rise_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> drdy_seen);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> ((cmd_valid && $stable(cmd_addr)) || seq_error));

  assert_clk_gated_writes_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_write) |-> !adc_clk_en);

  assert_null_is_read_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_null) |-> !cmd_write);

  assert_ready_after_sync_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(samples_ready) |-> (sync_seen && adc_sync_n));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    seq_error |=> seq_error);

  assert_err_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    seq_error |-> (!cmd_valid && !samples_ready && adc_sync_n));
endmodule

bind adc_pwrup_seq apu_checker #(.ADDR_W(ADDR_W)) u_apu_checker (
  .clk (clk), .rst (rst), .drdy (drdy), .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready), .cmd_write (cmd_write), .cmd_null (cmd_null),
  .cmd_addr (cmd_addr), .adc_clk_en (adc_clk_en), .adc_sync_n (adc_sync_n),
  .samples_ready (samples_ready), .seq_error (seq_error)
);

// File: tb/tb_adc_pwrup_seq.sv
`timescale 1ns/1ps
module tb_adc_pwrup_seq;
  localparam int ADDR_W = 6, DATA_W = 16, N_EXTRA = 2, N_WR = 3 + N_EXTRA;
  localparam int RISE_TMO = 200, POLL_TMO = 300, POLL_GAP = 8, SYNC_LEN = 4, DISCARD = 2;
  localparam int STATUS_ADDR = 1, SECFAIL_BIT = 12;

  logic clk = 0, rst = 1, drdy = 0, status_via_null = 0;
  logic [1:0] cfg_clk_div = 2'b10;
  logic [3:0] cfg_dcdc_freq = 4'h9;
  logic [N_EXTRA*DATA_W-1:0] cfg_extra = {16'hBEEF, 16'h1234};
  logic cmd_valid, cmd_ready = 0, cmd_write, cmd_null;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata;
  logic rsp_valid = 0;
  logic [DATA_W-1:0] rsp_rdata = 0;
  logic adc_clk_en, adc_sync_n, samples_ready, seq_error;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  logic s_got, s_w, s_n, s_clk;
  logic [ADDR_W-1:0] s_a;
  logic [DATA_W-1:0] s_d;
  int s_wait;

  always #5 clk = ~clk;

  adc_pwrup_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EXTRA(N_EXTRA), .TMO_W(12),
    .RISE_TMO(RISE_TMO), .POLL_TMO(POLL_TMO), .POLL_GAP(POLL_GAP),
    .SYNC_LEN(SYNC_LEN), .DISCARD(DISCARD)
  ) dut (
    .clk(clk), .rst(rst), .drdy(drdy), .status_via_null(status_via_null),
    .cfg_clk_div(cfg_clk_div), .cfg_dcdc_freq(cfg_dcdc_freq), .cfg_extra(cfg_extra),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_null(cmd_null), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .adc_clk_en(adc_clk_en),
    .adc_sync_n(adc_sync_n), .samples_ready(samples_ready), .seq_error(seq_error)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; drdy = 0; cmd_ready = 0; rsp_valid = 0; rsp_rdata = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic serve(input logic [DATA_W-1:0] rdata);
    s_got = 0; s_wait = 0;
    while (!cmd_valid && s_wait < 40) begin
      @(negedge clk);
      s_wait++;
    end
    if (cmd_valid) begin
      s_got = 1; s_w = cmd_write; s_n = cmd_null; s_a = cmd_addr; s_d = cmd_wdata;
      s_clk = adc_clk_en;
      cmd_ready = 1;
      @(negedge clk);
      cmd_ready = 0;
      repeat (2) @(negedge clk);
      rsp_rdata = rdata; rsp_valid = 1;
      @(negedge clk);
      rsp_valid = 0;
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr(input int k);
    case (k)
      0: return ADDR_W'(3);
      1, 2: return ADDR_W'(7);
      default: return ADDR_W'(16 + k - 3);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] exp_data(input int k);
    case (k)
      0: return DATA_W'(cfg_clk_div) << 8;
      1: return DATA_W'(cfg_dcdc_freq) << 4;
      2: return (DATA_W'(cfg_dcdc_freq) << 4) | 16'h0001;
      default: return cfg_extra[(k-3)*DATA_W +: DATA_W];
    endcase
  endfunction

  task automatic serve_config();
    for (int k = 0; k < N_WR; k++) begin
      serve('0);
      chk(s_got == 1, (k < 2) ? "R2 write issued" : "R3 write issued", s_got, 1);
      chk(s_w == 1 && s_a == exp_addr(k), (k < 2) ? "R2 addr" : "R3 addr", s_a, exp_addr(k));
      chk(s_d == exp_data(k), (k < 2) ? "R2 data" : "R3 data", s_d, exp_data(k));
      chk(s_clk == 0, "R4 clock gated during write", s_clk, 0);
    end
  endtask

  task automatic drdy_fall_pulse();
    drdy = 0; repeat (3) @(negedge clk);
    drdy = 1; repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset();
    chk(cmd_valid == 0, "R1 reset cmd_valid", cmd_valid, 0);
    chk(adc_clk_en == 0, "R4 reset clock gated", adc_clk_en, 0);
    chk(adc_sync_n == 1, "R9 reset sync idle", adc_sync_n, 1);
    chk(samples_ready == 0 && seq_error == 0, "R10 reset flags", {samples_ready, seq_error}, 0);
  endtask

  task automatic test_bringup(input bit mode);
    logic [DATA_W-1:0] resp [4];
    bit bad;
    int lo, wt;
    resp[0] = '0;
    resp[1] = DATA_W'(1) << SECFAIL_BIT;
    resp[2] = DATA_W'(1) << SECFAIL_BIT;
    resp[3] = '0;
    do_reset();
    status_via_null = mode;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (cmd_valid) bad = 1;
    end
    chk(!bad, "R1 no request before drdy rise", bad, 0);
    drdy = 1;
    serve_config();
    for (int p = 0; p < 4; p++) begin
      serve(resp[p]);
      chk(s_got == 1, (p == 1) ? "R5 poll after ignored read" : "R6 poll continues", s_got, 1);
      if (mode) chk(s_n == 1 && s_w == 0, "R7 NULL status request", {s_n, s_w}, 2'b10);
      else chk(s_n == 0 && s_w == 0 && s_a == ADDR_W'(STATUS_ADDR), "R7 register status read",
               {s_n, s_w, s_a}, STATUS_ADDR);
      if (p == 0) chk(s_clk == 1, "R4 clock on before status", s_clk, 1);
      else chk(s_wait >= POLL_GAP && s_wait <= POLL_GAP + 3, "R8 poll gap", s_wait, POLL_GAP);
    end
    wt = 0;
    while (adc_sync_n && wt < 30) begin @(negedge clk); wt++; end
    lo = 0;
    bad = 0;
    while (!adc_sync_n && lo < 100) begin
      if (samples_ready || cmd_valid) bad = 1;
      lo++;
      @(negedge clk);
    end
    chk(lo == SYNC_LEN, "R9 sync pulse width", lo, SYNC_LEN);
    chk(!bad, "R6 no poll and no ready during sync", bad, 0);
    drdy_fall_pulse();
    repeat (8) @(negedge clk);
    chk(samples_ready == 0, "R10 ready held after 1 discard", samples_ready, 0);
    drdy_fall_pulse();
    repeat (8) @(negedge clk);
    chk(samples_ready == 1, "R10 ready after discards", samples_ready, 1);
    repeat (20) @(negedge clk);
    chk(samples_ready == 1 && seq_error == 0, "R10 ready stays", {samples_ready, seq_error}, 2'b10);
  endtask

  task automatic test_rise_timeout();
    bit bad;
    do_reset();
    bad = 0;
    repeat (RISE_TMO + 30) begin
      @(negedge clk);
      if (cmd_valid) bad = 1;
    end
    chk(seq_error == 1, "R11 rise timeout error", seq_error, 1);
    drdy = 1;
    repeat (40) begin
      @(negedge clk);
      if (cmd_valid) bad = 1;
    end
    chk(!bad, "R11 no request after timeout", bad, 0);
    chk(seq_error == 1 && adc_clk_en == 0, "R11 error sticky, clock gated", {seq_error, adc_clk_en}, 2'b10);
  endtask

  task automatic test_poll_timeout();
    int n;
    do_reset();
    status_via_null = 1;
    repeat (10) @(negedge clk);
    drdy = 1;
    serve_config();
    n = 0;
    for (int i = 0; i < 60; i++) begin
      serve(DATA_W'(1) << SECFAIL_BIT);
      if (!s_got) break;
      n++;
    end
    chk(n > 2 && n < 60, "R12 polls before timeout", n, 20);
    chk(seq_error == 1, "R12 poll timeout error", seq_error, 1);
    chk(samples_ready == 0 && adc_sync_n == 1, "R12 no ready, no sync", {samples_ready, adc_sync_n}, 2'b01);
    repeat (50) @(negedge clk);
    chk(seq_error == 1 && cmd_valid == 0, "R12 error sticky", {seq_error, cmd_valid}, 2'b10);
  endtask

  initial begin
    test_reset();
    test_bringup(1'b1);
    test_bringup(1'b0);
    test_rise_timeout();
    test_poll_timeout();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule